// File: doc/BRIEF.md
# DMA Page Table Translator

This block turns a 32-bit address issued by a DMA-capable device into a physical memory address. It walks a single-level table that lives in system memory. A request carries one logical address. The block splits it into a 4 KiB page number and a page offset, and checks the page number against a programmed table size. For an index inside the table, it reads the entry's frame word through a simple memory-read port. The block answers with a physical address and a permission bit. A lookup outside the table, or a failed table read, gives a fault: the permission bit is clear and the address is zero.

Software sets two registers through a small write port: the table origin and the table size in bytes. Only one translation is in flight at a time. The block takes a copy of both registers when it accepts a request, so reprogramming them never disturbs a lookup that has already started.

Top module: `pgtbl_xlat`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0. Both registers read as zero, so every lookup faults and no memory read is issued.
- R2: For an index inside the table, one single-cycle `mem_req_valid` pulse is issued. Its address is the origin register with bit 31 forced to 0, plus the page index (logical address bits 31:12) times 8, modulo 2^32.
- R3: A lookup is in range only when the page index is strictly less than the size register shifted right by 3. The size bits 2:0 have no effect. An out-of-range lookup issues no memory read and answers `rsp_perm`=0 with `rsp_addr`=0.
- R4: A successful lookup answers `rsp_perm`=1 and `rsp_addr` = {frame word bits 31:12, logical address bits 11:0}. Frame word bits 11:0 are discarded.
- R5: A table read that returns `mem_rsp_err`=1 together with `mem_rsp_valid` answers `rsp_perm`=0 and `rsp_addr`=0.
- R6: From acceptance until the response handshake, `req_ready` is 0. While `rsp_valid` is 1 and `rsp_ready` is 0, `rsp_valid`, `rsp_addr` and `rsp_perm` hold their values.
- R7: A register write made after a request is accepted has no effect on that lookup. It applies to the next accepted request.
- R8: A register write in the same cycle a request is accepted does not affect that request. `cfg_wr_sel`=0 selects the origin register and `cfg_wr_sel`=1 selects the size register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_sel | input | 1 | 0 = table origin, 1 = table size in bytes |
| cfg_wr_data | input | 32 | Register write value |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_addr | input | 32 | Logical device address |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_addr | output | 32 | Physical address, zero on fault |
| rsp_perm | output | 1 | 1 = access permitted, 0 = fault |
| mem_req_valid | output | 1 | One-cycle table read request |
| mem_req_addr | output | 32 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Table read data present |
| mem_rsp_data | input | 32 | Frame word of the entry |
| mem_rsp_err | input | 1 | Table read failed |

## Verification
A register write can land in the same cycle a request is accepted. It can also land in any cycle while a lookup is in flight. The bench provokes the first by raising `cfg_wr_en` and `req_valid` at the same clock edge while the block is idle. It provokes the second by writing just after acceptance, while the memory reply is held back. In both cases the bench checks that the table read address and the in-range decision still follow the earlier values, and that the next request follows the new ones. A shrunken size makes that next request fault, and a moved origin moves the next entry fetch.

// File: rtl/pgtbl_pkg.sv
// Shared definitions for the page table translator.
// Assumes: a one-bit register select on the configuration write port.
package pgtbl_pkg;

    // Lookup sequencer states
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a request
        ST_CHECK,  // range check on the captured request
        ST_FETCH,  // table read request on the memory port
        ST_WAIT,   // waiting for the frame word
        ST_RESP    // result offered to the consumer
    } walk_state_t;

    // Register select codes on the configuration port
    localparam logic SEL_ORIGIN = 1'b0;
    localparam logic SEL_SIZE   = 1'b1;

endpackage

// File: rtl/pgtbl_cfg_regs.sv
// Holds the table origin and table size (bytes) written by software.
// Assumes: single write port, no read-back; both clear on reset.
module pgtbl_cfg_regs
    import pgtbl_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_data,
    output logic [ADDR_W-1:0] origin_q,
    output logic [ADDR_W-1:0] size_q
);

    // Register update: the select picks which register takes the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            origin_q <= '0;
            size_q   <= '0;
        end else if (wr_en) begin
            if (wr_sel == SEL_ORIGIN) begin
                origin_q <= wr_data;
            end else begin
                size_q <= wr_data;
            end
        end
    end

endmodule

// File: rtl/pgtbl_range_chk.sv
// Splits a logical address into a page index, decides whether the index
// lies inside the table, and forms the byte address of its entry.
// Assumes: entries are 2**ENTRY_SHIFT bytes; purely combinational.
module pgtbl_range_chk #(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int ENTRY_SHIFT = 3,
    parameter bit CLEAR_TOP   = 1'b1
) (
    input  logic [ADDR_W-1:0] laddr,
    input  logic [ADDR_W-1:0] origin,
    input  logic [ADDR_W-1:0] size_bytes,
    output logic              in_range,
    output logic [ADDR_W-1:0] entry_addr
);

    localparam int IDX_W = ADDR_W - PAGE_SHIFT;

    logic [IDX_W-1:0]      page_idx;
    logic [ADDR_W-1:0]     idx_ext;
    logic [ADDR_W-1:0]     entry_count;
    logic [ADDR_W-1:0]     origin_eff;
    logic [PAGE_SHIFT-1:0] unused_offset;

    assign page_idx      = laddr[ADDR_W-1:PAGE_SHIFT];
    assign unused_offset = laddr[PAGE_SHIFT-1:0];
    assign idx_ext       = {{PAGE_SHIFT{1'b0}}, page_idx};

    // Origin variant: optionally drop the top address bit before use
    generate
        if (CLEAR_TOP) begin : g_clear_top
            assign origin_eff = {1'b0, origin[ADDR_W-2:0]};
        end else begin : g_keep_top
            assign origin_eff = origin;
        end
    endgenerate

    // Table size in whole entries; a partial trailing entry does not count
    always_comb begin
        entry_count = size_bytes >> ENTRY_SHIFT;
        in_range    = (idx_ext < entry_count);
        entry_addr  = origin_eff + (idx_ext << ENTRY_SHIFT);
    end

endmodule

// File: rtl/pgtbl_compose.sv
// Builds the physical address from a frame word and a page offset.
// Assumes: the frame word's low PAGE_SHIFT bits carry no address meaning.
module pgtbl_compose #(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [ADDR_W-1:0] frame_word,
    input  logic [ADDR_W-1:0] laddr,
    output logic [ADDR_W-1:0] phys_addr
);

    logic [PAGE_SHIFT-1:0] unused_frame_low;

    assign unused_frame_low = frame_word[PAGE_SHIFT-1:0];

    // Frame number from the entry, offset from the request
    always_comb begin
        phys_addr = {frame_word[ADDR_W-1:PAGE_SHIFT], laddr[PAGE_SHIFT-1:0]};
    end

endmodule

// File: rtl/pgtbl_walker.sv
// Sequences one lookup at a time. It captures the request together with
// a copy of both registers, fetches the entry when in range, and holds
// the result until the consumer takes it.
// Assumes: memory replies arrive no earlier than the cycle after the
// request pulse; replies outside the wait state are ignored.
module pgtbl_walker
    import pgtbl_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [ADDR_W-1:0] cfg_origin,
    input  logic [ADDR_W-1:0] cfg_size,
    output logic [ADDR_W-1:0] snap_laddr,
    output logic [ADDR_W-1:0] snap_origin,
    output logic [ADDR_W-1:0] snap_size,
    input  logic              chk_in_range,
    input  logic [ADDR_W-1:0] chk_entry_addr,
    input  logic [ADDR_W-1:0] composed_addr,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_perm
);

    walk_state_t       state_q;
    logic [ADDR_W-1:0] laddr_q;
    logic [ADDR_W-1:0] origin_s_q;
    logic [ADDR_W-1:0] size_s_q;
    logic [ADDR_W-1:0] entry_q;
    logic [ADDR_W-1:0] phys_q;
    logic              perm_q;

    // Sequencer and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            laddr_q    <= '0;
            origin_s_q <= '0;
            size_s_q   <= '0;
            entry_q    <= '0;
            phys_q     <= '0;
            perm_q     <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        laddr_q    <= req_addr;
                        origin_s_q <= cfg_origin;
                        size_s_q   <= cfg_size;
                        state_q    <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    entry_q <= chk_entry_addr;
                    if (chk_in_range) begin
                        state_q <= ST_FETCH;
                    end else begin
                        perm_q  <= 1'b0;
                        phys_q  <= '0;
                        state_q <= ST_RESP;
                    end
                end
                ST_FETCH: begin
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rsp_valid) begin
                        if (mem_rsp_err) begin
                            perm_q <= 1'b0;
                            phys_q <= '0;
                        end else begin
                            perm_q <= 1'b1;
                            phys_q <= composed_addr;
                        end
                        state_q <= ST_RESP;
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Port outputs decoded from the sequencer state
    always_comb begin
        req_ready     = (state_q == ST_IDLE);
        mem_req_valid = (state_q == ST_FETCH);
        mem_req_addr  = entry_q;
        rsp_valid     = (state_q == ST_RESP);
        rsp_addr      = phys_q;
        rsp_perm      = perm_q;
        snap_laddr    = laddr_q;
        snap_origin   = origin_s_q;
        snap_size     = size_s_q;
    end

    // R6
    accept_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R6
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_addr) && $stable(rsp_perm)));

    // R2
    mem_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |=> !mem_req_valid);

    // R3
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_perm) |-> (rsp_addr == '0));

    // R4
    offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_perm) |->
            (rsp_addr[PAGE_SHIFT-1:0] == laddr_q[PAGE_SHIFT-1:0]));

    // R2
    no_fetch_outside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (!req_ready && !rsp_valid));

endmodule

// File: rtl/pgtbl_xlat.sv
// Top level of the page table translator: the register file, the lookup
// sequencer, the index/range logic and the address composer.
// Assumes: one lookup outstanding; memory port without back-pressure.
module pgtbl_xlat
    import pgtbl_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int PAGE_SHIFT  = 12,
    parameter int ENTRY_SHIFT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic              cfg_wr_sel,
    input  logic [ADDR_W-1:0] cfg_wr_data,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_perm,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    input  logic              mem_rsp_err
);

    logic [ADDR_W-1:0] origin_q;
    logic [ADDR_W-1:0] size_q;
    logic [ADDR_W-1:0] snap_laddr;
    logic [ADDR_W-1:0] snap_origin;
    logic [ADDR_W-1:0] snap_size;
    logic              in_range;
    logic [ADDR_W-1:0] entry_addr;
    logic [ADDR_W-1:0] phys_addr;

    pgtbl_cfg_regs #(
        .ADDR_W (ADDR_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr_en),
        .wr_sel   (cfg_wr_sel),
        .wr_data  (cfg_wr_data),
        .origin_q (origin_q),
        .size_q   (size_q)
    );

    pgtbl_range_chk #(
        .ADDR_W      (ADDR_W),
        .PAGE_SHIFT  (PAGE_SHIFT),
        .ENTRY_SHIFT (ENTRY_SHIFT),
        .CLEAR_TOP   (1'b1)
    ) u_range (
        .laddr      (snap_laddr),
        .origin     (snap_origin),
        .size_bytes (snap_size),
        .in_range   (in_range),
        .entry_addr (entry_addr)
    );

    pgtbl_compose #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_compose (
        .frame_word (mem_rsp_data),
        .laddr      (snap_laddr),
        .phys_addr  (phys_addr)
    );

    pgtbl_walker #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) u_walker (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .cfg_origin     (origin_q),
        .cfg_size       (size_q),
        .snap_laddr     (snap_laddr),
        .snap_origin    (snap_origin),
        .snap_size      (snap_size),
        .chk_in_range   (in_range),
        .chk_entry_addr (entry_addr),
        .composed_addr  (phys_addr),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .mem_rsp_valid  (mem_rsp_valid),
        .mem_rsp_err    (mem_rsp_err),
        .rsp_valid      (rsp_valid),
        .rsp_ready      (rsp_ready),
        .rsp_addr       (rsp_addr),
        .rsp_perm       (rsp_perm)
    );

endmodule

// File: tb/pgtbl_xlat_test.sv
`timescale 1ns/1ps
// Directed bench for the page table translator.
module pgtbl_xlat_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_wr_en;
    logic        cfg_wr_sel;
    logic [31:0] cfg_wr_data;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic        rsp_valid;
    logic        rsp_ready;
    logic [31:0] rsp_addr;
    logic        rsp_perm;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid;
    logic [31:0] mem_rsp_data;
    logic        mem_rsp_err;

    int          n_chk = 0;
    int          n_bad = 0;
    int          mem_cnt = 0;
    logic [31:0] mem_last = '0;
    int          lat = 2;
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;

    always #10 clk = ~clk;

    pgtbl_xlat uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_wr_sel    (cfg_wr_sel),
        .cfg_wr_data   (cfg_wr_data),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_addr      (rsp_addr),
        .rsp_perm      (rsp_perm),
        .mem_req_valid (mem_req_valid),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .mem_rsp_err   (mem_rsp_err)
    );

    // Table contents: frame word as a function of its byte address
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return (a ^ 32'h5A5A_0F0F) * 32'h0001_0003 + 32'h0000_0ABC;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Memory model: answers each request after 'lat' falling edges
    initial begin
        mem_rsp_valid = 1'b0;
        mem_rsp_data  = '0;
        mem_rsp_err   = 1'b0;
        forever begin
            @(negedge clk);
            if (mem_req_valid === 1'b1) begin
                logic [31:0] a;
                a = mem_req_addr;
                mem_cnt++;
                mem_last = a;
                repeat (lat) @(negedge clk);
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = mem_word(a);
                mem_rsp_err   = err_en && (a == err_addr);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                mem_rsp_err   = 1'b0;
            end
        end
    end

    task automatic cfg_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_sel  = sel;
        cfg_wr_data = data;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    // One translation. exp_org/exp_size are the register values that
    // must govern it; optional writes in the accept cycle or after it.
    task automatic xlat(input string tag, input logic [31:0] addr,
                        input logic [31:0] exp_org, input logic [31:0] exp_size,
                        input int hold, input bit mid_wr, input bit same_wr,
                        input logic wsel, input logic [31:0] wdata);
        logic [31:0] idx, eaddr, frame, exp_phys;
        logic        hit, bad, exp_perm;
        int          c0, t;
        idx      = addr >> 12;
        hit      = idx < (exp_size >> 3);
        eaddr    = {1'b0, exp_org[30:0]} + (idx << 3);
        frame    = mem_word(eaddr);
        bad      = err_en && (eaddr == err_addr);
        exp_perm = hit && !bad;
        exp_phys = exp_perm ? {frame[31:12], addr[11:0]} : 32'h0;
        c0       = mem_cnt;

        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = addr;
        if (same_wr) begin
            cfg_wr_en   = 1'b1;
            cfg_wr_sel  = wsel;
            cfg_wr_data = wdata;
        end
        while (req_ready !== 1'b1) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_wr_en = 1'b0;
        if (mid_wr) begin
            cfg_wr_en   = 1'b1;
            cfg_wr_sel  = wsel;
            cfg_wr_data = wdata;
            @(negedge clk);
            cfg_wr_en = 1'b0;
        end
        t = 0;
        while (rsp_valid !== 1'b1 && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk({tag, " R6 response arrives"}, {31'h0, rsp_valid}, 32'h1);
        for (int i = 0; i < hold; i++) begin
            chk({tag, " R6 busy while result pending"}, {31'h0, req_ready}, 32'h0);
            @(negedge clk);
            chk({tag, " R6 result held"}, {31'h0, rsp_valid}, 32'h1);
            chk({tag, " R6 address held"}, rsp_addr, exp_phys);
        end
        chk({tag, " perm"}, {31'h0, rsp_perm}, {31'h0, exp_perm});
        chk({tag, " addr"}, rsp_addr, exp_phys);
        chk({tag, " fetch count"}, mem_cnt - c0, hit ? 32'h1 : 32'h0);
        if (hit) chk({tag, " R2 entry address"}, mem_last, eaddr);
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk({tag, " R6 result released"}, {31'h0, rsp_valid}, 32'h0);
        chk({tag, " R6 ready again"}, {31'h0, req_ready}, 32'h1);
    endtask

    task automatic t_reset();
        chk("R1 req_ready after reset", {31'h0, req_ready}, 32'h1);
        chk("R1 rsp_valid after reset", {31'h0, rsp_valid}, 32'h0);
        chk("R1 mem_req_valid after reset", {31'h0, mem_req_valid}, 32'h0);
        xlat("R1 zero table faults", 32'h0000_0123, 32'h0, 32'h0, 0, 0, 0, 1'b0, 32'h0);
    endtask

    task automatic t_basic();
        cfg_write(1'b0, 32'h0001_0000);
        cfg_write(1'b1, 32'h0000_0100);
        xlat("R4 index 5", 32'h0000_5ABC, 32'h0001_0000, 32'h100, 0, 0, 0, 1'b0, 32'h0);
        xlat("R4 index 0", 32'h0000_0FFF, 32'h0001_0000, 32'h100, 0, 0, 0, 1'b0, 32'h0);
        lat = 1;
        xlat("R4 short latency", 32'h0001_F001, 32'h0001_0000, 32'h100, 0, 0, 0, 1'b0, 32'h0);
        lat = 6;
        xlat("R4 long latency", 32'h0000_A7E4, 32'h0001_0000, 32'h100, 0, 0, 0, 1'b0, 32'h0);
        lat = 2;
    endtask

    task automatic t_origin_mask();
        cfg_write(1'b0, 32'h8002_0000);
        xlat("R2 top origin bit cleared", 32'h0000_3010, 32'h8002_0000, 32'h100, 0, 0, 0, 1'b0, 32'h0);
        cfg_write(1'b0, 32'hFFFF_F000);
        cfg_write(1'b1, 32'hFFFF_FFFF);
        xlat("R2 top index", 32'hFFFF_F123, 32'hFFFF_F000, 32'hFFFF_FFFF, 0, 0, 0, 1'b0, 32'h0);
    endtask

    task automatic t_limits();
        cfg_write(1'b0, 32'h0003_0000);
        cfg_write(1'b1, 32'h0000_0047);
        xlat("R3 last entry in range", 32'h0000_7555, 32'h0003_0000, 32'h47, 0, 0, 0, 1'b0, 32'h0);
        xlat("R3 first entry past size", 32'h0000_8555, 32'h0003_0000, 32'h47, 0, 0, 0, 1'b0, 32'h0);
        cfg_write(1'b1, 32'h0000_0008);
        xlat("R3 single entry hit", 32'h0000_0042, 32'h0003_0000, 32'h8, 0, 0, 0, 1'b0, 32'h0);
        xlat("R3 single entry miss", 32'h0000_1042, 32'h0003_0000, 32'h8, 0, 0, 0, 1'b0, 32'h0);
        cfg_write(1'b1, 32'h0000_0007);
        xlat("R3 partial entry not counted", 32'h0000_0042, 32'h0003_0000, 32'h7, 0, 0, 0, 1'b0, 32'h0);
    endtask

    task automatic t_mem_error();
        cfg_write(1'b1, 32'h0000_0100);
        err_en   = 1'b1;
        err_addr = 32'h0003_0000 + 32'd3 * 32'd8;
        xlat("R5 failed table read", 32'h0000_3ABC, 32'h0003_0000, 32'h100, 0, 0, 0, 1'b0, 32'h0);
        xlat("R5 other entry unaffected", 32'h0000_4ABC, 32'h0003_0000, 32'h100, 0, 0, 0, 1'b0, 32'h0);
        err_en = 1'b0;
    endtask

    task automatic t_hold();
        xlat("R6 held hit", 32'h0000_2468, 32'h0003_0000, 32'h100, 4, 0, 0, 1'b0, 32'h0);
        xlat("R6 held fault", 32'h0010_2468, 32'h0003_0000, 32'h100, 3, 0, 0, 1'b0, 32'h0);
    endtask

    task automatic t_inflight();
        lat = 4;
        xlat("R7 origin write in flight", 32'h0000_2111, 32'h0003_0000, 32'h100, 0, 1, 0, 1'b0, 32'h0004_0000);
        xlat("R7 new origin next request", 32'h0000_2111, 32'h0004_0000, 32'h100, 0, 0, 0, 1'b0, 32'h0);
        xlat("R7 size write in flight", 32'h0000_2111, 32'h0004_0000, 32'h100, 0, 1, 0, 1'b1, 32'h0);
        xlat("R7 new size next request", 32'h0000_2111, 32'h0004_0000, 32'h0, 0, 0, 0, 1'b0, 32'h0);
        lat = 2;
    endtask

    task automatic t_same_cycle();
        cfg_write(1'b1, 32'h0000_0100);
        xlat("R8 size write at accept", 32'h0000_1777, 32'h0004_0000, 32'h100, 0, 0, 1, 1'b1, 32'h8);
        xlat("R8 size write applied", 32'h0000_1777, 32'h0004_0000, 32'h8, 0, 0, 0, 1'b0, 32'h0);
        xlat("R8 origin write at accept", 32'h0000_0777, 32'h0004_0000, 32'h8, 0, 0, 1, 1'b0, 32'h0005_0000);
        xlat("R8 origin write applied", 32'h0000_0777, 32'h0005_0000, 32'h8, 0, 0, 0, 1'b0, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R6 watchdog actual=hung expected=complete");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n       = 1'b0;
        cfg_wr_en   = 1'b0;
        cfg_wr_sel  = 1'b0;
        cfg_wr_data = '0;
        req_valid   = 1'b0;
        req_addr    = '0;
        rsp_ready   = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_origin_mask();
        t_limits();
        t_mem_error();
        t_hold();
        t_inflight();
        t_same_cycle();
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule